// File: doc/BRIEF.md
# SDRAM Bank Command Tracker

This block sits on the device side of a four-bank synchronous DRAM command bus. On every rising clock edge it samples chip select, the three strobes, the address bus and the two bank-select pins. It decodes the command, checks it against the current state, and updates its own record of that state. For each bank it keeps whether the bank is open and which row is open. It also keeps a small mode record, the progress of a write burst, and the deferred closing of a bank after a write with auto-precharge.

It does not store data. It is used where a model or a monitor of the memory must know which rows are open and which column a write beat lands on, and must flag any command that breaks the bank rules. The mode record is unknown after reset. Until a mode load is accepted, every access is refused.

Top module: `sdram_bank_tracker`

## Requirements
- R1: Commands are decoded from the active-low pins {cs_n, ras_n, cas_n, we_n}, with these codes: 0011 activate, 0100 write, 0010 precharge, 0001 refresh, 0000 mode load. Any other code is ignored, and any code with cs_n high is also ignored: it changes no output and raises no flag.
- R2: The bank index is {bank_pin_hi, bank_pin_lo}. Pins hi=0, lo=1 select bank 1, and pins hi=1, lo=0 select bank 2.
- R3: An accepted activate sets bank_open[b] and latches addr[12:0] as that bank's row, visible in open_rows[b*13 +: 13] one cycle later. An activate to an open bank is refused and leaves the bank's row and state unchanged.
- R4: After reset, mode_valid is 0 and no bank is open. An activate or a write issued while mode_valid is 0 is refused. Once set, mode_valid stays set.
- R5: A mode load takes the burst code from addr[2:0] (0, 1, 2, 3 select 1, 2, 4, 8 beats) and the single-write bit from addr[9]. It is accepted only when every bank is idle. A burst code of 4 to 7 is refused and leaves the mode unchanged.
- R6: An accepted write starts a burst. wr_active is high for as many cycles as the burst has beats, starting the cycle after the command. wr_col starts at addr[9:0] and increments with wrap-around inside the aligned block of burst-length columns.
- R7: In single-write mode, a write lasts one beat whatever the burst code.
- R8: A write with addr[10]=1 keeps its bank open through the last beat. The bank closes in the cycle in which wr_active falls.
- R9: A write to an idle bank is refused. So is a write issued while wr_active is high.
- R10: A precharge with addr[10]=0 closes only the addressed bank. With addr[10]=1 it closes all banks. While wr_active is high, a precharge that would close the burst's bank is refused.
- R11: A refresh is accepted only when all banks are idle, and then gives a one-cycle pulse on refresh_start. Otherwise it is refused.
- R12: A refused command raises cmd_illegal for exactly the one cycle after that command, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_pin_hi | input | 1 | High-order bank-select pin |
| bank_pin_lo | input | 1 | Low-order bank-select pin |
| addr | input | 13 | Row, column, auto-precharge and mode fields |
| bank_open | output | 4 | One bit per bank, set while the bank is open |
| open_rows | output | 52 | Open row per bank, 13 bits each, bank 0 lowest |
| wr_active | output | 1 | A write burst beat is in progress |
| wr_bank | output | 2 | Bank of the current write beat |
| wr_col | output | 10 | Column of the current write beat |
| mode_valid | output | 1 | A mode load has been accepted |
| cmd_illegal | output | 1 | The previous command was refused |
| refresh_start | output | 1 | The previous command started a refresh |

## Verification
The assertions take the pins as settled before each rising edge. They also assume that reset is held for at least one edge before any command arrives. An assertion that a burst stays inside one column block relies on the mode not changing while a bank is open. This holds because mode loads are refused unless every bank is idle. The stimulus drives pins only on falling edges and holds reset for several cycles. Its pseudo-random phase draws every command code, deselects and reserved burst codes, so refused commands are exercised alongside accepted ones. An independent model judges each of them.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS,
    CMD_OTHER
  } cmd_e;

  // Active-low pin pattern to command; cs_n high is a deselect.
  function automatic cmd_e pins_to_cmd(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) begin
      c = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_MRS;
        3'b111:  c = CMD_NOP;
        default: c = CMD_OTHER;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              bank_pin_hi,
  input  logic              bank_pin_lo,
  output cmd_e              cmd,
  output logic [BANK_W-1:0] bank_idx
);

  always_comb begin
    cmd      = pins_to_cmd(cs_n, ras_n, cas_n, we_n);
    // the high-order pin carries the upper bit of the bank number
    bank_idx = BANK_W'({bank_pin_hi, bank_pin_lo});
  end

endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg #(
  parameter int BL_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BL_W-1:0] bl_in,
  input  logic            single_in,
  output logic            valid,
  output logic [BL_W-1:0] bl_code,
  output logic            single
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      bl_code <= '0;
      single  <= 1'b0;
    end else if (load) begin
      valid   <= 1'b1;
      bl_code <= bl_in;
      single  <= single_in;
    end
  end

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(valid) |-> valid); // R4

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_req,
  input  logic             close_req,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_q,
  output logic [ROW_W-1:0] row_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (open_req) begin
      open_q <= 1'b1;
      row_q  <= row_in;
    end else if (close_req) begin
      open_q <= 1'b0;
    end
  end

  AST_OPEN_NEEDS_ACT: assert property (@(posedge clk) disable iff (rst)
    $rose(open_q) |-> $past(open_req)); // R3

  AST_ROW_HELD: assert property (@(posedge clk) disable iff (rst)
    (open_q && $past(open_q)) |-> $stable(row_q)); // R3

endmodule

// File: rtl/sdram_wr_burst.sv
module sdram_wr_burst #(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2,
  parameter int BL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic [BANK_W-1:0] start_bank,
  input  logic [BL_W-1:0]   bl_code,
  input  logic              single,
  input  logic              auto_pre,
  output logic              busy,
  output logic [COL_W-1:0]  col,
  output logic [BANK_W-1:0] bank,
  output logic              ap_q,
  output logic              done
);

  localparam int MAX_BEATS = 1 << ((1 << BL_W) - 1);
  localparam int CNT_W     = $clog2(MAX_BEATS) + 1;

  logic [CNT_W-1:0] left_q;
  logic [COL_W-1:0] mask_q;
  logic [COL_W-1:0] start_mask;
  logic [COL_W-1:0] col_inc;

  always_comb begin
    start_mask = single ? '0 : COL_W'((32'd1 << bl_code) - 32'd1);
    col_inc    = col + COL_W'(1);
    done       = busy && (left_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      col    <= '0;
      bank   <= '0;
      ap_q   <= 1'b0;
      left_q <= '0;
      mask_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      col    <= start_col;
      bank   <= start_bank;
      ap_q   <= auto_pre;
      left_q <= CNT_W'(start_mask);
      mask_q <= start_mask;
    end else if (busy) begin
      if (left_q == '0) begin
        busy <= 1'b0;
      end else begin
        left_q <= left_q - CNT_W'(1);
        col    <= (col & ~mask_q) | (col_inc & mask_q);
      end
    end
  end

  AST_COL_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(start)) |->
      ((col & ~mask_q) == ($past(col) & ~mask_q))); // R6

  AST_BANK_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(start)) |-> $stable(bank)); // R6

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int SW_BIT    = 9,
  parameter int BL_W      = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic                       bank_pin_hi,
  input  logic                       bank_pin_lo,
  input  logic [ADDR_W-1:0]          addr,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic                       wr_active,
  output logic [$clog2(NUM_BANKS)-1:0] wr_bank,
  output logic [COL_W-1:0]           wr_col,
  output logic                       mode_valid,
  output logic                       cmd_illegal,
  output logic                       refresh_start
);

  localparam int BANK_W = $clog2(NUM_BANKS);

  cmd_e              cmd;
  logic [BANK_W-1:0] bsel;
  logic              ap_bit;
  logic [BL_W-1:0]   mode_bl;
  logic              mode_single;
  logic              burst_done;
  logic              burst_ap;

  logic              cmd_ok;
  logic              do_act, do_wr, do_pre_one, do_pre_all, do_ref, do_mrs;
  logic [NUM_BANKS-1:0] open_req, close_req;
  logic              bl_reserved;

  sdram_cmd_decode #(.BANK_W(BANK_W)) u_decode (
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .bank_pin_hi (bank_pin_hi),
    .bank_pin_lo (bank_pin_lo),
    .cmd         (cmd),
    .bank_idx    (bsel)
  );

  assign ap_bit      = addr[AP_BIT];
  assign bl_reserved = |addr[ADDR_W-1:BL_W] & addr[BL_W];

  // legality of the sampled command against the pre-edge state
  always_comb begin
    cmd_ok = 1'b1;
    unique case (cmd)
      CMD_ACT: cmd_ok = mode_valid && !bank_open[bsel];
      CMD_WR:  cmd_ok = mode_valid && bank_open[bsel] && !wr_active;
      CMD_PRE: cmd_ok = ap_bit ? !wr_active : !(wr_active && wr_bank == bsel);
      CMD_REF: cmd_ok = (bank_open == '0);
      CMD_MRS: cmd_ok = (bank_open == '0) && !bl_reserved;
      default: cmd_ok = 1'b1;
    endcase
  end

  always_comb begin
    do_act     = (cmd == CMD_ACT) && cmd_ok;
    do_wr      = (cmd == CMD_WR)  && cmd_ok;
    do_pre_one = (cmd == CMD_PRE) && cmd_ok && !ap_bit;
    do_pre_all = (cmd == CMD_PRE) && cmd_ok && ap_bit;
    do_ref     = (cmd == CMD_REF) && cmd_ok;
    do_mrs     = (cmd == CMD_MRS) && cmd_ok;
  end

  sdram_mode_reg #(.BL_W(BL_W)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .load      (do_mrs),
    .bl_in     (addr[BL_W-1:0]),
    .single_in (addr[SW_BIT]),
    .valid     (mode_valid),
    .bl_code   (mode_bl),
    .single    (mode_single)
  );

  sdram_wr_burst #(.COL_W(COL_W), .BANK_W(BANK_W), .BL_W(BL_W)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .start      (do_wr),
    .start_col  (addr[COL_W-1:0]),
    .start_bank (bsel),
    .bl_code    (mode_bl),
    .single     (mode_single),
    .auto_pre   (ap_bit),
    .busy       (wr_active),
    .col        (wr_col),
    .bank       (wr_bank),
    .ap_q       (burst_ap),
    .done       (burst_done)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign open_req[b]  = do_act && (bsel == BANK_W'(b));
    assign close_req[b] = do_pre_all
                        || (do_pre_one && (bsel == BANK_W'(b)))
                        || (burst_done && burst_ap && (wr_bank == BANK_W'(b)));

    sdram_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .open_req  (open_req[b]),
      .close_req (close_req[b]),
      .row_in    (addr[ROW_W-1:0]),
      .open_q    (bank_open[b]),
      .row_q     (open_rows[b*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_illegal   <= 1'b0;
      refresh_start <= 1'b0;
    end else begin
      cmd_illegal   <= !cmd_ok;
      refresh_start <= do_ref;
    end
  end

  AST_BURST_BANK_OPEN: assert property (@(posedge clk) disable iff (rst)
    wr_active |-> bank_open[wr_bank]); // R8

  AST_NO_OPEN_BEFORE_MODE: assert property (@(posedge clk) disable iff (rst)
    !mode_valid |-> (bank_open == '0)); // R4

  AST_REF_ALL_IDLE: assert property (@(posedge clk) disable iff (rst)
    refresh_start |-> ($past(bank_open) == '0)); // R11

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(cmd_illegal && refresh_start)); // R12

endmodule

// File: tb/sdram_bank_tracker_bench.sv
module sdram_bank_tracker_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic        bank_pin_hi = 1'b0, bank_pin_lo = 1'b0;
  logic [12:0] addr = '0;
  logic [3:0]  bank_open;
  logic [51:0] open_rows;
  logic        wr_active;
  logic [1:0]  wr_bank;
  logic [9:0]  wr_col;
  logic        mode_valid, cmd_illegal, refresh_start;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sdram_bank_tracker u_sdram_bank_tracker (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bank_pin_hi(bank_pin_hi), .bank_pin_lo(bank_pin_lo), .addr(addr),
    .bank_open(bank_open), .open_rows(open_rows), .wr_active(wr_active),
    .wr_bank(wr_bank), .wr_col(wr_col), .mode_valid(mode_valid),
    .cmd_illegal(cmd_illegal), .refresh_start(refresh_start)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit          m_open [4];
  int          m_row  [4];
  bit          m_mode;
  int          m_blen;
  bit          m_single;
  bit          m_busy;
  int          m_left, m_col, m_bank, m_block;
  bit          m_ap, m_ill, m_ref;
  bit          cmp_en = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; end
      m_mode = 0; m_blen = 1; m_single = 0; m_busy = 0; m_left = 0;
      m_col = 0; m_bank = 0; m_block = 1; m_ap = 0; m_ill = 0; m_ref = 0;
      cmp_en = 0;
    end else begin
      int  b, kind;
      bit  ok, any_open;
      b = bank_pin_hi * 2 + bank_pin_lo;
      any_open = m_open[0] | m_open[1] | m_open[2] | m_open[3];
      kind = 0;
      if (!cs_n) begin
        case ({ras_n, cas_n, we_n})
          3'b011: kind = 1;
          3'b100: kind = 2;
          3'b010: kind = 3;
          3'b001: kind = 4;
          3'b000: kind = 5;
          default: kind = 0;
        endcase
      end
      ok = 1;
      case (kind)
        1: ok = m_mode && !m_open[b];
        2: ok = m_mode && m_open[b] && !m_busy;
        3: ok = addr[10] ? !m_busy : !(m_busy && m_bank == b);
        4: ok = !any_open;
        5: ok = !any_open && addr[2:0] < 4;
        default: ok = 1;
      endcase
      m_ill = !ok;
      m_ref = (kind == 4) && ok;
      if (m_busy) begin
        if (m_left == 0) begin
          m_busy = 0;
          if (m_ap) m_open[m_bank] = 0;
        end else begin
          m_left = m_left - 1;
          m_col = (m_col / m_block) * m_block + ((m_col % m_block) + 1) % m_block;
        end
      end
      if (ok) begin
        case (kind)
          1: begin m_open[b] = 1; m_row[b] = addr; end
          2: begin
               m_busy = 1; m_col = addr[9:0]; m_bank = b; m_ap = addr[10];
               m_block = m_single ? 1 : m_blen;
               m_left = m_block - 1;
             end
          3: if (addr[10]) for (int i = 0; i < 4; i++) m_open[i] = 0;
             else m_open[b] = 0;
          5: begin m_mode = 1; m_blen = 1 << addr[1:0]; m_single = addr[9]; end
          default: ;
        endcase
      end
      cmp_en = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !rst && !finished) begin
      for (int i = 0; i < 4; i++) begin
        chk("R3 bank_open", 64'(bank_open[i]), 64'(m_open[i]));
        chk("R3 open_row", 64'(open_rows[i*13 +: 13]), 64'(m_row[i]));
      end
      chk("R6 wr_active", 64'(wr_active), 64'(m_busy));
      if (m_busy) begin
        chk("R6 wr_col", 64'(wr_col), 64'(m_col));
        chk("R6 wr_bank", 64'(wr_bank), 64'(m_bank));
      end
      chk("R4 mode_valid", 64'(mode_valid), 64'(m_mode));
      chk("R12 cmd_illegal", 64'(cmd_illegal), 64'(m_ill));
      chk("R11 refresh_start", 64'(refresh_start), 64'(m_ref));
    end
  end

  // ---------------- stimulus ----------------
  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_WR = 4'b0100,
                         P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000,
                         P_DES = 4'b1011;

  task automatic send(input logic [3:0] p, input logic hi, input logic lo,
                      input logic [12:0] a);
    {cs_n, ras_n, cas_n, we_n} = p;
    bank_pin_hi = hi; bank_pin_lo = lo; addr = a;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
  endtask

  task automatic idle();
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
    @(negedge clk);
  endtask

  logic [31:0] rng = 32'h1234_5678;
  function automatic logic [31:0] step_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 reset mode_valid", 64'(mode_valid), 64'd0);
    chk("R4 reset bank_open", 64'(bank_open), 64'd0);

    send(P_ACT, 0, 0, 13'h0005);
    chk("R4 act before mode refused", 64'(cmd_illegal), 64'd1);
    chk("R4 no bank opened", 64'(bank_open), 64'd0);

    send(P_MRS, 0, 0, 13'h0005);
    chk("R5 reserved burst refused", 64'(cmd_illegal), 64'd1);
    chk("R5 mode unchanged", 64'(mode_valid), 64'd0);

    send(P_MRS, 0, 0, 13'h0002);
    chk("R5 mode loaded", 64'(mode_valid), 64'd1);

    send(P_ACT, 1, 0, 13'h1ABC);
    chk("R2 hi pin selects bank 2", 64'(bank_open), 64'h4);
    chk("R3 row latched", 64'(open_rows[26 +: 13]), 64'h1ABC);
    send(P_ACT, 0, 1, 13'h0123);
    chk("R2 lo pin selects bank 1", 64'(bank_open), 64'h6);

    send(P_ACT, 1, 0, 13'h0777);
    chk("R3 act to open bank refused", 64'(cmd_illegal), 64'd1);
    chk("R3 row kept", 64'(open_rows[26 +: 13]), 64'h1ABC);

    send(P_DES, 0, 0, 13'h0042);
    chk("R1 deselect ignored", 64'(bank_open), 64'h6);
    chk("R1 deselect no flag", 64'(cmd_illegal), 64'd0);

    send(P_WR, 0, 1, 13'h0006);
    chk("R6 burst first col", 64'(wr_col), 64'h006);
    chk("R6 burst bank", 64'(wr_bank), 64'd1);
    send(P_WR, 1, 0, 13'h0010);
    chk("R9 write during burst refused", 64'(cmd_illegal), 64'd1);
    chk("R6 second col", 64'(wr_col), 64'h007);
    idle();
    chk("R6 wrapped col", 64'(wr_col), 64'h004);
    idle();
    chk("R6 last col", 64'(wr_col), 64'h005);
    idle();
    chk("R6 burst over", 64'(wr_active), 64'd0);
    chk("R8 no auto close", 64'(bank_open), 64'h6);

    send(P_WR, 0, 0, 13'h0000);
    chk("R9 write to idle bank refused", 64'(cmd_illegal), 64'd1);
    send(P_REF, 0, 0, 13'h0000);
    chk("R11 refresh with open banks refused", 64'(cmd_illegal), 64'd1);

    send(P_WR, 1, 0, 13'h07F9);
    chk("R6 ap burst col", 64'(wr_col), 64'h3F9);
    idle(); idle(); idle();
    chk("R6 ap burst wrapped", 64'(wr_col), 64'h3F8);
    chk("R8 bank open on last beat", 64'(bank_open), 64'h6);
    idle();
    chk("R8 bank closed after burst", 64'(bank_open), 64'h2);

    send(P_ACT, 0, 0, 13'h0001);
    send(P_ACT, 1, 1, 13'h0002);
    chk("R2 both pins bank 3", 64'(bank_open), 64'hB);
    send(P_PRE, 0, 0, 13'h0000);
    chk("R10 single precharge", 64'(bank_open), 64'hA);
    send(P_PRE, 0, 0, 13'h0400);
    chk("R10 precharge all", 64'(bank_open), 64'h0);

    send(P_REF, 0, 0, 13'h0000);
    chk("R11 refresh pulse", 64'(refresh_start), 64'd1);
    idle();
    chk("R11 refresh pulse ends", 64'(refresh_start), 64'd0);

    send(P_MRS, 0, 0, 13'h0203);
    send(P_ACT, 1, 1, 13'h0009);
    send(P_WR, 1, 1, 13'h0455);
    chk("R7 single write col", 64'(wr_col), 64'h055);
    idle();
    chk("R7 single write one beat", 64'(wr_active), 64'd0);
    chk("R8 single write auto close", 64'(bank_open), 64'h0);

    send(P_ACT, 0, 0, 13'h0003);
    send(P_MRS, 0, 0, 13'h0001);
    chk("R5 mode load with open bank refused", 64'(cmd_illegal), 64'd1);
    send(P_PRE, 0, 0, 13'h0400);

    for (int n = 0; n < 3000; n++) begin
      logic [3:0] p;
      logic [12:0] a;
      rng = step_rng(rng);
      case (rng[2:0])
        3'd0, 3'd1: p = P_NOP;
        3'd2: p = P_ACT;
        3'd3: p = P_WR;
        3'd4: p = P_PRE;
        3'd5: p = P_REF;
        3'd6: p = P_MRS;
        default: p = {1'b1, rng[5:3]};
      endcase
      a = rng[20:8];
      if (rng[2:0] == 3'd4 && rng[23:21] != 0) a[10] = 1'b0;
      send(p, rng[6], rng[7], a);
    end
    idle();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule